// File: doc/BRIEF.md
# Accumulator Microcontroller Core (8-bit data, 12-bit instructions)

This block is a small 8-bit processor with a single working register W. It runs a reduced instruction set of fixed 12-bit words. The program sits in a 256-word image inside the block. That image is supplied as a parameter when the block is instantiated, and an 8-bit program counter walks it. All arithmetic and logic takes W as one operand. For file-register operations, one destination bit in the instruction sends the result either to W or back to the addressed register.

Data is addressed through one flat 5-bit register space:
- Address 5 is a 4-bit port.
- Addresses 6 and 7 are 8-bit ports.
- Addresses 8 to 31 are general-purpose registers.
- Addresses 0 to 4 read as zero and ignore writes.

Each port has an output latch, a pin input and a direction register (1 = input). A port read takes the pin where the direction bit is 1 and the latch where it is 0.

The core has a one-deep fetch register, so it completes one instruction per clock. When a bit test skips, or when a GOTO, CALL or RETLW transfers control, the instruction already fetched is turned into a no-op. A two-entry return stack serves CALL and RETLW. The active-low master clear is asynchronous.

Top module: `acc8_core`

## Requirements
- R1: While master clear is low, the PC is 0, W is 0, every port direction bit is 1, every output latch is 0 and every general register is 0.
- R2: After master clear is released, the instruction at address a of a straight-line program takes effect on the (a+2)-th rising edge. This holds while no GOTO, CALL or RETLW has executed.
- R3: TRIS (0x005, 0x006, 0x007 for addresses 5, 6, 7) copies W into that port's direction register. MOVWF f (0x020|f) copies W to f, and a write to a port address sets its output latch.
- R4: For MOVF (0x200), INCF (0x280), ADDWF (0x1C0), ANDWF (0x140) and SWAPF (0x380), bit 5 selects the destination. A 0 writes W and leaves f unchanged; a 1 writes f and leaves W unchanged. Bits [4:0] are f.
- R5: INCF adds one modulo 256, ADDWF adds W and f modulo 256, ANDWF gives W AND f, and SWAPF exchanges the two nibbles of f.
- R6: CLRF f (0x060|f) writes 0 to f. CLRW (0x040) writes 0 to W.
- R7: Reading a port returns the pin bit where the direction bit is 1 and the latch bit where it is 0. The 4-bit port reads with its upper four bits as 0.
- R8: BTFSC (0x600|b<<5|f) skips the next instruction when bit b of f is 0, and BTFSS (0x700|b<<5|f) skips it when that bit is 1. A skipped instruction changes nothing, and a test that does not skip costs no cycle.
- R9: GOTO (0xA00|k) and CALL (0x900|k) jump to k, and CALL saves the address after itself. RETLW (0x800|k) loads k into W and returns. Calls nest two deep. Each transfer adds one no-op cycle.
- R10: Writes to addresses 0 to 4 change nothing, and those addresses read as 0. Addresses 8 to 31 hold the last value written.
- R11: Instruction words outside the listed encodings (for example 0x0FF) execute as no-ops.
- R12: A GOTO or CALL that a taken skip turns into a no-op does not redirect the program and does not push the stack.
- R13: MOVLW (0xC00|k) loads the literal k into W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| mclr_n | input | 1 | Asynchronous master clear, active low |
| pa_pin | input | 4 | Pin levels of the 4-bit port (address 5) |
| pa_out | output | 4 | Output latch of the 4-bit port |
| pa_dir | output | 4 | Direction of the 4-bit port, 1 = input |
| pb_pin | input | 8 | Pin levels of port at address 6 |
| pb_out | output | 8 | Output latch of port at address 6 |
| pb_dir | output | 8 | Direction of port at address 6, 1 = input |
| pc_pin | input | 8 | Pin levels of port at address 7 |
| pc_out | output | 8 | Output latch of port at address 7 |
| pc_dir | output | 8 | Direction of port at address 7, 1 = input |

## Verification
The delicate overlap is a taken skip that lands in the same cycle as the fetch of a GOTO or CALL. The squash has to win over the redirect that this fetched word would otherwise cause. The test program places a GOTO and a CALL that both aim at a trap routine, each directly behind a skipping bit test; the trap writes a marker to port B. The bench then checks two things at exact edges: the values written after the skips appear on schedule, and the marker is never seen, which also shows the call stack stayed intact for the real nested calls that follow.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int DW    = 8;   // data path width
    localparam int IW    = 12;  // instruction word width
    localparam int PC_W  = 8;   // program counter width
    localparam int FA_W  = 5;   // file address width

    typedef enum logic [3:0] {
        OP_NOP, OP_MOVWF, OP_CLRW, OP_CLRF, OP_MOVF, OP_INCF, OP_ADDWF,
        OP_ANDWF, OP_SWAPF, OP_BTFSC, OP_BTFSS, OP_TRIS, OP_MOVLW,
        OP_RETLW, OP_CALL, OP_GOTO
    } op_e;

    typedef struct packed {
        op_e             op;
        logic            to_file;
        logic [FA_W-1:0] fa;
        logic [2:0]      bsel;
        logic [DW-1:0]   lit;
    } dec_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [IW-1:0]   ir;
        logic            live;
        logic [DW-1:0]   w;
    } core_t;
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [IW-1:0] ir,
    output dec_t          dec
);
    always_comb begin
        dec.op      = OP_NOP;
        dec.to_file = ir[5];
        dec.fa      = ir[4:0];
        dec.bsel    = ir[7:5];
        dec.lit     = ir[7:0];
        case (ir[11:8])
            4'h0: begin
                case (ir[7:5])
                    3'b000: if (ir[4:3] == 2'b00 && ir[2:0] >= 3'd5) dec.op = OP_TRIS;
                    3'b001: dec.op = OP_MOVWF;
                    3'b010: if (ir[4:0] == 5'd0) dec.op = OP_CLRW;
                    3'b011: dec.op = OP_CLRF;
                    default: dec.op = OP_NOP;
                endcase
            end
            4'h1: begin
                if (ir[7:6] == 2'b01) dec.op = OP_ANDWF;
                else if (ir[7:6] == 2'b11) dec.op = OP_ADDWF;
            end
            4'h2: begin
                if (ir[7:6] == 2'b00) dec.op = OP_MOVF;
                else if (ir[7:6] == 2'b10) dec.op = OP_INCF;
            end
            4'h3: if (ir[7:6] == 2'b10) dec.op = OP_SWAPF;
            4'h6: dec.op = OP_BTFSC;
            4'h7: dec.op = OP_BTFSS;
            4'h8: dec.op = OP_RETLW;
            4'h9: dec.op = OP_CALL;
            4'hA: dec.op = OP_GOTO;
            4'hC: dec.op = OP_MOVLW;
            default: dec.op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int W = DW
) (
    input  op_e          op,
    input  logic [W-1:0] w_in,
    input  logic [W-1:0] f_in,
    input  logic [W-1:0] lit,
    output logic [W-1:0] y
);
    localparam int HALF = W / 2;

    always_comb begin
        case (op)
            OP_MOVF:  y = f_in;
            OP_INCF:  y = f_in + W'(1);
            OP_ADDWF: y = w_in + f_in;
            OP_ANDWF: y = w_in & f_in;
            OP_SWAPF: y = {f_in[HALF-1:0], f_in[W-1:HALF]};
            OP_CLRF,
            OP_CLRW:  y = '0;
            OP_MOVLW,
            OP_RETLW: y = lit;
            default:  y = w_in;
        endcase
    end
endmodule

// File: rtl/acc8_stack.sv
module acc8_stack #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         mclr_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top
);
    logic [DEPTH-1:0][W-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) ent_d[i] = ent_q[i-1];
            ent_d[0] = push_val;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
        end
    end

    always_ff @(posedge clk or negedge mclr_n) begin
        if (!mclr_n) ent_q <= '0;
        else         ent_q <= ent_d;
    end

    assign top = ent_q[0];

    // R9
    push_top_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        push |=> (top == $past(push_val)));
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile #(
    parameter int DW      = 8,
    parameter int AW      = 5,
    parameter int PA_W    = 4,
    parameter int GP_BASE = 8
) (
    input  logic          clk,
    input  logic          mclr_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          tris_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [PA_W-1:0] pa_pin,
    output logic [PA_W-1:0] pa_lat,
    output logic [PA_W-1:0] pa_dir,
    input  logic [DW-1:0] pb_pin,
    output logic [DW-1:0] pb_lat,
    output logic [DW-1:0] pb_dir,
    input  logic [DW-1:0] pc_pin,
    output logic [DW-1:0] pc_lat,
    output logic [DW-1:0] pc_dir
);
    localparam int NGP  = (2 ** AW) - GP_BASE;
    localparam int GI_W = $clog2(NGP);
    localparam logic [AW-1:0] A_PA = AW'(5);
    localparam logic [AW-1:0] A_PB = AW'(6);
    localparam logic [AW-1:0] A_PC = AW'(7);

    typedef struct packed {
        logic [NGP-1:0][DW-1:0] gp;
        logic [PA_W-1:0]        pa_lat;
        logic [PA_W-1:0]        pa_dir;
        logic [DW-1:0]          pb_lat;
        logic [DW-1:0]          pb_dir;
        logic [DW-1:0]          pc_lat;
        logic [DW-1:0]          pc_dir;
    } rf_t;

    localparam rf_t RF_RST = '{gp: '0, pa_lat: '0, pa_dir: '1,
                               pb_lat: '0, pb_dir: '1, pc_lat: '0, pc_dir: '1};

    rf_t s_d, s_q;
    logic            in_gp;
    logic [GI_W-1:0] gidx;

    assign in_gp = (addr >= AW'(GP_BASE));
    assign gidx  = GI_W'(addr - AW'(GP_BASE));

    // read side: pin where direction is input, latch where it is output
    always_comb begin
        rdata = '0;
        if (in_gp) rdata = s_q.gp[gidx];
        else if (addr == A_PA)
            rdata = {{(DW-PA_W){1'b0}}, (s_q.pa_dir & pa_pin) | (~s_q.pa_dir & s_q.pa_lat)};
        else if (addr == A_PB)
            rdata = (s_q.pb_dir & pb_pin) | (~s_q.pb_dir & s_q.pb_lat);
        else if (addr == A_PC)
            rdata = (s_q.pc_dir & pc_pin) | (~s_q.pc_dir & s_q.pc_lat);
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (in_gp)              s_d.gp[gidx] = wdata;
            else if (addr == A_PA)  s_d.pa_lat   = wdata[PA_W-1:0];
            else if (addr == A_PB)  s_d.pb_lat   = wdata;
            else if (addr == A_PC)  s_d.pc_lat   = wdata;
        end
        if (tris_en) begin
            if (addr == A_PA)       s_d.pa_dir = wdata[PA_W-1:0];
            else if (addr == A_PB)  s_d.pb_dir = wdata;
            else if (addr == A_PC)  s_d.pc_dir = wdata;
        end
    end

    always_ff @(posedge clk or negedge mclr_n) begin
        if (!mclr_n) s_q <= RF_RST;
        else         s_q <= s_d;
    end

    assign pa_lat = s_q.pa_lat;
    assign pa_dir = s_q.pa_dir;
    assign pb_lat = s_q.pb_lat;
    assign pb_dir = s_q.pb_dir;
    assign pc_lat = s_q.pc_lat;
    assign pc_dir = s_q.pc_dir;

    // R3
    tris_b_load_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        (tris_en && addr == A_PB) |=> (pb_dir == $past(wdata)));

    // R10
    reserved_wr_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        (wr_en && addr < A_PA) |=> ($stable(pa_lat) && $stable(pb_lat) && $stable(pc_lat)));
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int STACK_DEPTH = 2,
    parameter int PA_W        = 4,
    parameter logic [IW*(2**PC_W)-1:0] PROG_IMAGE = '0
) (
    input  logic            clk,
    input  logic            mclr_n,
    input  logic [PA_W-1:0] pa_pin,
    output logic [PA_W-1:0] pa_out,
    output logic [PA_W-1:0] pa_dir,
    input  logic [DW-1:0]   pb_pin,
    output logic [DW-1:0]   pb_out,
    output logic [DW-1:0]   pb_dir,
    input  logic [DW-1:0]   pc_pin,
    output logic [DW-1:0]   pc_out,
    output logic [DW-1:0]   pc_dir
);
    localparam int PROG_DEPTH = 2 ** PC_W;

    logic [IW-1:0] rom [PROG_DEPTH];

    for (genvar i = 0; i < PROG_DEPTH; i++) begin : g_rom
        assign rom[i] = PROG_IMAGE[i*IW +: IW];
    end

    core_t s_d, s_q;
    dec_t  dec;
    logic [DW-1:0]   rd_data, alu_y;
    logic [PC_W-1:0] stk_top;
    logic exe, rf_we, tris_we, push, pop, skip_taken;

    assign exe = s_q.live;

    acc8_decode u_dec (.ir(s_q.ir), .dec(dec));

    acc8_alu #(.W(DW)) u_alu (
        .op(dec.op), .w_in(s_q.w), .f_in(rd_data), .lit(dec.lit), .y(alu_y)
    );

    acc8_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stk (
        .clk(clk), .mclr_n(mclr_n), .push(push), .pop(pop),
        .push_val(s_q.pc), .top(stk_top)
    );

    acc8_regfile #(.DW(DW), .AW(FA_W), .PA_W(PA_W), .GP_BASE(8)) u_rf (
        .clk(clk), .mclr_n(mclr_n), .addr(dec.fa), .wr_en(rf_we),
        .tris_en(tris_we), .wdata(alu_y), .rdata(rd_data),
        .pa_pin(pa_pin), .pa_lat(pa_out), .pa_dir(pa_dir),
        .pb_pin(pb_pin), .pb_lat(pb_out), .pb_dir(pb_dir),
        .pc_pin(pc_pin), .pc_lat(pc_out), .pc_dir(pc_dir)
    );

    always_comb begin
        s_d        = s_q;
        s_d.pc     = s_q.pc + PC_W'(1);
        s_d.ir     = rom[s_q.pc];
        s_d.live   = 1'b1;
        rf_we      = 1'b0;
        tris_we    = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        skip_taken = 1'b0;
        if (exe) begin
            case (dec.op)
                OP_MOVWF, OP_CLRF: rf_we = 1'b1;
                OP_CLRW, OP_MOVLW: s_d.w = alu_y;
                OP_MOVF, OP_INCF, OP_ADDWF, OP_ANDWF, OP_SWAPF: begin
                    if (dec.to_file) rf_we = 1'b1;
                    else             s_d.w = alu_y;
                end
                OP_BTFSC: skip_taken = ~rd_data[dec.bsel];
                OP_BTFSS: skip_taken =  rd_data[dec.bsel];
                OP_TRIS:  tris_we = 1'b1;
                OP_GOTO: begin
                    s_d.pc   = dec.lit;
                    s_d.live = 1'b0;
                end
                OP_CALL: begin
                    push     = 1'b1;
                    s_d.pc   = dec.lit;
                    s_d.live = 1'b0;
                end
                OP_RETLW: begin
                    pop      = 1'b1;
                    s_d.pc   = stk_top;
                    s_d.w    = alu_y;
                    s_d.live = 1'b0;
                end
                default: ;
            endcase
            if (skip_taken) s_d.live = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge mclr_n) begin
        if (!mclr_n) s_q <= '0;
        else         s_q <= s_d;
    end

    // R8
    skip_squash_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        skip_taken |=> !(rf_we || tris_we || push || pop));

    // R9
    call_target_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        (exe && dec.op == OP_CALL) |=> (s_q.pc == $past(dec.lit)));
endmodule

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;
    localparam int CLK_P = 4;

    function automatic logic [3071:0] make_image();
        logic [3071:0] m;
        m = '0;
        m[12*0  +: 12] = 12'h006; // TRIS port B  (W=0)
        m[12*1  +: 12] = 12'hC0F;
        m[12*2  +: 12] = 12'h007; // TRIS port C
        m[12*3  +: 12] = 12'hCA5;
        m[12*4  +: 12] = 12'h026; // -> A5
        m[12*5  +: 12] = 12'h028;
        m[12*6  +: 12] = 12'h3A8; // SWAPF 8,1
        m[12*7  +: 12] = 12'h208;
        m[12*8  +: 12] = 12'h026; // -> 5A
        m[12*9  +: 12] = 12'hCFF;
        m[12*10 +: 12] = 12'h029;
        m[12*11 +: 12] = 12'h2A9; // INCF 9,1 wraps
        m[12*12 +: 12] = 12'h1C9; // ADDWF 9,0
        m[12*13 +: 12] = 12'h026; // -> FF
        m[12*14 +: 12] = 12'hCC8;
        m[12*15 +: 12] = 12'h02A;
        m[12*16 +: 12] = 12'hC64;
        m[12*17 +: 12] = 12'h1CA;
        m[12*18 +: 12] = 12'h026; // -> 2C
        m[12*19 +: 12] = 12'hC3C;
        m[12*20 +: 12] = 12'h16A; // ANDWF 10,1
        m[12*21 +: 12] = 12'h026; // -> 3C
        m[12*22 +: 12] = 12'h1CA;
        m[12*23 +: 12] = 12'h026; // -> 44
        m[12*24 +: 12] = 12'h06A; // CLRF 10
        m[12*25 +: 12] = 12'h040; // CLRW
        m[12*26 +: 12] = 12'h1CA;
        m[12*27 +: 12] = 12'h026; // -> 00
        m[12*28 +: 12] = 12'hCA0;
        m[12*29 +: 12] = 12'h027; // port C latch A0
        m[12*30 +: 12] = 12'h207;
        m[12*31 +: 12] = 12'h026; // -> AC
        m[12*32 +: 12] = 12'h205;
        m[12*33 +: 12] = 12'h026; // -> 09
        m[12*34 +: 12] = 12'h023; // write to reserved address 3
        m[12*35 +: 12] = 12'h203;
        m[12*36 +: 12] = 12'h026; // -> 00
        m[12*37 +: 12] = 12'hC31;
        m[12*38 +: 12] = 12'h0FF; // undefined
        m[12*39 +: 12] = 12'h026; // -> 31
        m[12*40 +: 12] = 12'hC12;
        m[12*41 +: 12] = 12'h02B;
        m[12*42 +: 12] = 12'h60B; // BTFSC 11,0 skips
        m[12*43 +: 12] = 12'hCEE;
        m[12*44 +: 12] = 12'h026; // -> 12
        m[12*45 +: 12] = 12'h72B; // BTFSS 11,1 skips
        m[12*46 +: 12] = 12'hA3C; // squashed GOTO trap
        m[12*47 +: 12] = 12'h68B; // BTFSC 11,4 no skip
        m[12*48 +: 12] = 12'hC5B;
        m[12*49 +: 12] = 12'h026; // -> 5B
        m[12*50 +: 12] = 12'h60B; // skips
        m[12*51 +: 12] = 12'h93C; // squashed CALL trap
        m[12*52 +: 12] = 12'h937; // CALL 0x37
        m[12*53 +: 12] = 12'h026; // -> 4F
        m[12*54 +: 12] = 12'hA36; // GOTO self
        m[12*55 +: 12] = 12'h93A; // CALL 0x3A
        m[12*56 +: 12] = 12'h026; // -> 7E
        m[12*57 +: 12] = 12'h84F; // RETLW 4F
        m[12*58 +: 12] = 12'h87E; // RETLW 7E
        m[12*60 +: 12] = 12'hCE1; // trap
        m[12*61 +: 12] = 12'h026;
        m[12*62 +: 12] = 12'hA3E;
        return m;
    endfunction

    localparam logic [3071:0] IMG = make_image();

    logic clk = 1'b0;
    logic mclr_n = 1'b0;
    logic [3:0] pa_pin = 4'h9;
    logic [7:0] pb_pin = 8'h00;
    logic [7:0] pc_pin = 8'h5C;
    logic [3:0] pa_out, pa_dir;
    logic [7:0] pb_out, pb_dir, pc_out, pc_dir;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) if (mclr_n) edge_n <= edge_n + 1;

    acc8_core #(.PROG_IMAGE(IMG)) u0 (
        .clk(clk), .mclr_n(mclr_n),
        .pa_pin(pa_pin), .pa_out(pa_out), .pa_dir(pa_dir),
        .pb_pin(pb_pin), .pb_out(pb_out), .pb_dir(pb_dir),
        .pc_pin(pc_pin), .pc_out(pc_out), .pc_dir(pc_dir)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic at_edge(int n);
        while (edge_n < n) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 pa_dir", {4'h0, pa_dir}, 8'h0F);
        chk("R1 pb_dir", pb_dir, 8'hFF);
        chk("R1 pc_dir", pc_dir, 8'hFF);
        chk("R1 pb_out", pb_out, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        mclr_n = 1'b1;
    endtask

    task automatic t_timing;
        at_edge(1); chk("R2 dir before edge 2", pb_dir, 8'hFF);
        at_edge(2); chk("R2 R3 TRIS at edge 2", pb_dir, 8'h00);
        at_edge(4); chk("R3 TRIS port C", pc_dir, 8'h0F);
        at_edge(5); chk("R2 out before edge 6", pb_out, 8'h00);
        at_edge(6); chk("R2 R13 MOVWF at edge 6", pb_out, 8'hA5);
    endtask

    task automatic t_alu;
        at_edge(10); chk("R4 R5 SWAPF to f, MOVF to W", pb_out, 8'h5A);
        at_edge(15); chk("R5 INCF wrap", pb_out, 8'hFF);
        at_edge(20); chk("R5 ADDWF mod 256", pb_out, 8'h2C);
        at_edge(23); chk("R4 ANDWF d=1 keeps W", pb_out, 8'h3C);
        at_edge(25); chk("R5 ANDWF result in f", pb_out, 8'h44);
        at_edge(29); chk("R6 CLRF and CLRW", pb_out, 8'h00);
    endtask

    task automatic t_ports;
        at_edge(31); chk("R3 port C latch", pc_out, 8'hA0);
        at_edge(33); chk("R7 mixed pin/latch read", pb_out, 8'hAC);
        at_edge(35); chk("R7 4-bit port read", pb_out, 8'h09);
        at_edge(38); chk("R10 reserved address", pb_out, 8'h00);
        at_edge(41); chk("R11 undefined word", pb_out, 8'h31);
    endtask

    task automatic t_skips;
        at_edge(46); chk("R8 BTFSC skip", pb_out, 8'h12);
        at_edge(51); chk("R8 R12 BTFSS skip over GOTO", pb_out, 8'h5B);
    endtask

    task automatic t_calls;
        at_edge(59); chk("R9 R12 before return value", pb_out, 8'h5B);
        at_edge(60); chk("R9 nested RETLW", pb_out, 8'h7E);
        at_edge(62); chk("R9 transfer bubble", pb_out, 8'h7E);
        at_edge(63); chk("R9 outer RETLW", pb_out, 8'h4F);
        at_edge(120); chk("R12 no trap marker", pb_out, 8'h4F);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timing();
        t_alu();
        t_ports();
        t_skips();
        t_calls();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule